// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block sits between a serial deserializer and a host read port. Each character the deserializer finishes arrives on the push side with three per-character flags: break, framing error and parity error. The character and its flags are stored in a 16-entry first-in first-out ring. One extra character may wait in a holding slot once the ring is full. The host pops the oldest entry, and its byte and flags are visible on the read outputs whenever the queue is not empty.

The block produces a status byte. Bit 0 is a ready bit and bit 1 is a full bit. Bits 7:4 are sticky error bits for break, framing, parity and overrun. Bits 3:2 belong to the transmit side and read as zero here. Error bits gather either when an entry becomes the oldest one (the default) or at the moment a character is accepted. A one-way command selects the second behaviour. A five-bit command port clears the errors, resets the receive side and selects the accumulation mode. A separate write port turns the receiver on or off. After a break character is stored, further characters are refused until the deserializer reports that the line has been marking for half a bit time.

Top module: `rxq_top`

## Requirements
- R1: The ring holds DEPTH (16) entries in arrival order. `level` shows how many entries are stored, and `rd_data`/`rd_brk`/`rd_fe`/`rd_pe` show the oldest entry whenever `level` is nonzero. The holding slot is not counted in `level`.
- R2: `stat[0]` is 1 whenever the ring holds at least one entry. It rises at the clock edge that accepts a character into an empty ring and falls only at the edge where a pop empties the ring.
- R3: `stat[1]` is 1 exactly when `level` equals 16.
- R4: A character accepted while the ring is full, with the holding slot empty and no pop, waits in the holding slot. A pop in that state moves the waiting character into the ring at the same edge, so `level` stays 16 and `stat[1]` stays set until a second pop.
- R5: A character accepted while the ring is full, the holding slot is occupied and there is no pop is lost along with its flags, and `stat[4]` (overrun) is set.
- R6: A pop and an accepted push in the same cycle leave `level` unchanged when the ring is not empty.
- R7: In the default mode, the break, framing and parity flags of an entry are ORed into `stat[7]`, `stat[6]` and `stat[5]` one edge after the entry becomes the oldest one. Each entry contributes once.
- R8: Command code 5'b01101 switches to push-time accumulation. The flags of each character accepted into the ring or the holding slot are ORed into `stat[7:5]` at the accepting edge, and the head-time gathering stops. Only command 5'b00010 or `rst` leaves this mode.
- R9: Command code 5'b00100 clears `stat[7:4]` at the next edge. The clear wins over any accumulation in that same cycle, and flags already gathered from an entry are not gathered again.
- R10: Command code 5'b00010 empties the ring and the holding slot, clears `stat[7:4]`, the accumulation mode and the break block, and turns the receiver off. Push, pop and enable writes in that cycle have no effect.
- R11: The receiver is off after `rst`. A cycle with `en_wr` high loads `en_val` into `rx_on`. While `rx_on` is 0, pushes are ignored.
- R12: Once a character with its break flag set has been stored, later pushes are ignored until a cycle with `line_mark` high. Only one position is taken by the break.
- R13: A pop while `level` is 0 has no effect. `stat[3:2]` are always 0. Command codes other than 5'b00010, 5'b00100 and 5'b01101 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Deserializer offers one completed character this cycle |
| push_data | input | 8 | Character byte |
| push_brk | input | 1 | Character is a received break |
| push_fe | input | 1 | Character had a framing error |
| push_pe | input | 1 | Character had a parity error |
| line_mark | input | 1 | Line has been marking for half a bit time; releases the break block |
| pop | input | 1 | Host read of the oldest entry |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| en_wr | input | 1 | Write strobe for the receiver on/off state |
| en_val | input | 1 | Receiver on/off value |
| stat | output | 8 | {brk, fe, pe, overrun, 0, 0, full, ready} |
| level | output | 5 | Entries stored in the ring |
| rd_data | output | 8 | Byte of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| rd_fe | output | 1 | Framing flag of the oldest entry |
| rd_pe | output | 1 | Parity flag of the oldest entry |
| rx_on | output | 1 | Receiver is on |

## Verification
The hardest case to reach is the boundary between the holding slot and overrun. The ring has to be full and the slot occupied, and then a push has to arrive either alone (overrun) or together with a pop (slot to ring, new character to slot). Random traffic rarely lines this up, so a directed sequence fills the ring to 16, adds a seventeenth and eighteenth character, and then pairs pops with pushes. After that, random phases with a strong push bias and a strong pop bias keep the queue near both the full and empty edges, and occasional commands switch the accumulation mode, clear errors and reset the receiver.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rxq_flags_t;

    typedef struct packed {
        rxq_flags_t              flg;
        logic [DATA_W-1:0]       data;
    } rxq_ent_t;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
        logic oe;
    } rxq_err_t;

    typedef enum logic [4:0] {
        CMD_NONE        = 5'b00000,
        CMD_RX_RESET    = 5'b00010,
        CMD_ERR_CLEAR   = 5'b00100,
        CMD_ACC_ON_PUSH = 5'b01101
    } rxq_cmd_e;

    // OR a set of character flags into an error word when sel is high
    function automatic rxq_err_t fold_flags(input rxq_err_t e, input rxq_flags_t f, input logic sel);
        rxq_err_t r;
        r     = e;
        r.brk = e.brk | (sel & f.brk);
        r.fe  = e.fe  | (sel & f.fe);
        r.pe  = e.pe  | (sel & f.pe);
        return r;
    endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  rxq_ent_t      wr_ent,
    input  logic          rd_en,
    output rxq_ent_t      head,
    output logic [CW-1:0] count
);

    rxq_ent_t         mem [DEPTH];
    logic [PW-1:0]    wp;
    logic [PW-1:0]    rp;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_en) wp <= bump(wp);
            if (rd_en) rp <= bump(rp);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_ent;
    end

    assign head = mem[rp];

    // R1: a write with no read never lands on a full ring
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |-> (count != CW'(DEPTH)));

    // R13: no read is issued to an empty ring
    p_no_underflow_r13: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (count != '0));

endmodule

// File: rtl/rxq_admit.sv
module rxq_admit
    import rxq_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push_v,
    input  rxq_ent_t      push_ent,
    input  logic          pop_req,
    input  logic [CW-1:0] count,
    input  logic          en_wr,
    input  logic          en_val,
    input  logic          line_mark,
    output logic          ring_wr,
    output rxq_ent_t      ring_ent,
    output logic          ring_rd,
    output logic          ovr,
    output logic          stored,
    output logic          hold_v,
    output logic          rx_en,
    output logic          blk
);

    rxq_ent_t hold_q;
    logic     full;
    logic     accept;
    logic     room;
    logic     hold_load;
    logic     hold_drop;

    assign full    = (count == CW'(DEPTH));
    assign ring_rd = pop_req && (count != '0) && !flush;
    assign accept  = push_v && rx_en && !blk && !flush;
    assign room    = !full || ring_rd;

    always_comb begin
        ring_wr   = 1'b0;
        ring_ent  = push_ent;
        ovr       = 1'b0;
        hold_load = 1'b0;
        hold_drop = 1'b0;
        if (hold_v && ring_rd) begin
            ring_wr   = 1'b1;
            ring_ent  = hold_q;
            hold_load = accept;
            hold_drop = !accept;
        end else if (accept && room) begin
            ring_wr   = 1'b1;
        end else if (accept && !hold_v) begin
            hold_load = 1'b1;
        end else if (accept) begin
            ovr       = 1'b1;
        end
    end

    assign stored = accept && !ovr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hold_q <= '0;
            hold_v <= 1'b0;
            rx_en  <= 1'b0;
            blk    <= 1'b0;
        end else begin
            if (hold_load) begin
                hold_q <= push_ent;
                hold_v <= 1'b1;
            end else if (hold_drop) begin
                hold_v <= 1'b0;
            end
            if (en_wr) rx_en <= en_val;
            if (stored && push_ent.flg.brk) blk <= 1'b1;
            else if (line_mark)             blk <= 1'b0;
        end
    end

    // R4: the waiting slot is only occupied while the ring is full
    p_hold_needs_full_r4: assert property (@(posedge clk) disable iff (rst)
        hold_v |-> full);

    // R12: the break block persists until the line reports marking
    p_block_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (blk && !line_mark && !flush) |=> blk);

endmodule

// File: rtl/rxq_errs.sv
module rxq_errs
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       clr,
    input  logic       mode_set,
    input  rxq_flags_t head_flags,
    input  logic       nz,
    input  logic       popped,
    input  logic       push_acc,
    input  rxq_flags_t push_flags,
    input  logic       ovr,
    output rxq_err_t   err,
    output logic       push_mode
);

    logic     seen;
    rxq_err_t acc;

    always_comb begin
        acc    = '0;
        acc    = fold_flags(acc, head_flags, !push_mode && nz && !seen);
        acc    = fold_flags(acc, push_flags, push_mode && push_acc);
        acc.oe = ovr;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            err       <= '0;
            seen      <= 1'b0;
            push_mode <= 1'b0;
        end else begin
            err       <= clr ? rxq_err_t'('0) : (err | acc);
            if (popped)  seen <= 1'b0;
            else if (nz) seen <= 1'b1;
            push_mode <= push_mode | mode_set;
        end
    end

    // R9: a clear command empties every error bit
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !flush) |=> (err == '0));

    // R5: an overrun is recorded unless cleared in that cycle
    p_overrun_seen_r5: assert property (@(posedge clk) disable iff (rst)
        (ovr && !clr && !flush) |=> err.oe);

    // R8: push-time mode is left only by a receiver reset
    p_mode_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (push_mode && !flush) |=> push_mode);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_brk,
    input  logic              push_fe,
    input  logic              push_pe,
    input  logic              line_mark,
    input  logic              pop,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_code,
    input  logic              en_wr,
    input  logic              en_val,
    output logic [7:0]        stat,
    output logic [CW-1:0]     level,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_brk,
    output logic              rd_fe,
    output logic              rd_pe,
    output logic              rx_on
);

    logic     flush, clr, mode_set;
    rxq_ent_t push_ent, ring_ent, head;
    logic     ring_wr, ring_rd, ovr, stored, hold_v, blk, push_mode;
    rxq_err_t err;

    assign flush    = cmd_valid && (cmd_code == CMD_RX_RESET);
    assign clr      = cmd_valid && (cmd_code == CMD_ERR_CLEAR);
    assign mode_set = cmd_valid && (cmd_code == CMD_ACC_ON_PUSH);

    assign push_ent.flg.brk = push_brk;
    assign push_ent.flg.fe  = push_fe;
    assign push_ent.flg.pe  = push_pe;
    assign push_ent.data    = push_data;

    rxq_admit #(.DEPTH(DEPTH)) u_admit (
        .clk(clk), .rst(rst), .flush(flush),
        .push_v(push_valid), .push_ent(push_ent), .pop_req(pop),
        .count(level), .en_wr(en_wr), .en_val(en_val), .line_mark(line_mark),
        .ring_wr(ring_wr), .ring_ent(ring_ent), .ring_rd(ring_rd),
        .ovr(ovr), .stored(stored), .hold_v(hold_v), .rx_en(rx_on), .blk(blk)
    );

    rxq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(ring_wr), .wr_ent(ring_ent), .rd_en(ring_rd),
        .head(head), .count(level)
    );

    rxq_errs u_errs (
        .clk(clk), .rst(rst), .flush(flush), .clr(clr), .mode_set(mode_set),
        .head_flags(head.flg), .nz(level != '0), .popped(ring_rd),
        .push_acc(stored), .push_flags(push_ent.flg), .ovr(ovr),
        .err(err), .push_mode(push_mode)
    );

    assign rd_data = head.data;
    assign rd_brk  = head.flg.brk;
    assign rd_fe   = head.flg.fe;
    assign rd_pe   = head.flg.pe;

    assign stat = {err.brk, err.fe, err.pe, err.oe, 2'b00,
                   level == CW'(DEPTH), level != '0};

    // R11: with the receiver off and no pop, the ring level does not move
    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!rx_on && !pop && !flush) |=> $stable(level));

    // R4: popping with a waiting character keeps the ring full
    p_full_persists_r4: assert property (@(posedge clk) disable iff (rst)
        (hold_v && pop && !flush) |=> (level == CW'(DEPTH)));

    // R6: a read paired with a write leaves the level unchanged
    p_pair_level_r6: assert property (@(posedge clk) disable iff (rst)
        (ring_rd && ring_wr) |=> $stable(level));

    // R12: nothing is stored while the break block is up
    p_block_no_store_r12: assert property (@(posedge clk) disable iff (rst)
        (blk && !pop && !flush) |=> $stable(level));

endmodule

// File: tb/rxq_top_test.sv
`timescale 1ns/1ps
module rxq_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       push_valid, push_brk, push_fe, push_pe, line_mark, pop;
    logic [7:0] push_data;
    logic       cmd_valid, en_wr, en_val;
    logic [4:0] cmd_code;
    logic [7:0] stat;
    logic [4:0] level;
    logic [7:0] rd_data;
    logic       rd_brk, rd_fe, rd_pe, rx_on;

    always #2.5 clk = ~clk;

    rxq_top uut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .push_brk(push_brk), .push_fe(push_fe), .push_pe(push_pe),
        .line_mark(line_mark), .pop(pop), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .en_wr(en_wr), .en_val(en_val), .stat(stat),
        .level(level), .rd_data(rd_data), .rd_brk(rd_brk), .rd_fe(rd_fe),
        .rd_pe(rd_pe), .rx_on(rx_on)
    );

    // reference state derived from the requirements
    logic [10:0] mq[$];
    logic [10:0] mh;
    bit          mhv, men, mblk, mmode, mseen;
    logic [3:0]  merr;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R7";

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        return {merr, 2'b00, mq.size() == 16, mq.size() != 0};
    endfunction

    task automatic model_step();
        int          cnt;
        bit          dpop, acc_ok, ovr, stored;
        logic [3:0]  acc;
        logic [10:0] ne;
        ne = {push_brk, push_fe, push_pe, push_data};
        if (rst || (cmd_valid && cmd_code == 5'b00010)) begin
            mq.delete(); mhv = 0; men = 0; mblk = 0; mmode = 0; merr = 0; mseen = 0;
        end else begin
            cnt = mq.size();
            dpop = pop && cnt > 0;
            acc = '0; ovr = 0;
            if (!mmode && cnt > 0 && !mseen) acc[3:1] = mq[0][10:8];
            if (dpop) mseen = 0; else if (cnt > 0) mseen = 1;
            acc_ok = push_valid && men && !mblk;
            if (dpop) void'(mq.pop_front());
            if (mhv && dpop) begin mq.push_back(mh); mhv = 0; end
            if (acc_ok) begin
                if (mq.size() < 16) mq.push_back(ne);
                else if (!mhv) begin mh = ne; mhv = 1; end
                else ovr = 1;
            end
            stored = acc_ok && !ovr;
            if (mmode && stored) acc[3:1] = acc[3:1] | ne[10:8];
            acc[0] = ovr;
            if (line_mark) mblk = 0;
            if (stored && ne[10]) mblk = 1;
            merr = (cmd_valid && cmd_code == 5'b00100) ? 4'b0 : (merr | acc);
            if (cmd_valid && cmd_code == 5'b01101) mmode = 1;
            if (en_wr) men = en_val;
        end
    endtask

    task automatic idle_inputs();
        push_valid = 0; push_data = '0; push_brk = 0; push_fe = 0; push_pe = 0;
        line_mark = 0; pop = 0; cmd_valid = 0; cmd_code = '0; en_wr = 0; en_val = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        chk(level == 5'(mq.size()), "R1", "level", level, mq.size());
        chk(stat[0] == exp_stat()[0], "R2", "ready", stat[0], exp_stat()[0]);
        chk(stat[1] == exp_stat()[1], "R3", "full", stat[1], exp_stat()[1]);
        chk(stat[7:4] == merr, cur_tag, "errors", stat[7:4], merr);
        chk(stat[3:2] == 2'b00, "R13", "tx bits", stat[3:2], 0);
        chk(rx_on == men, "R11", "rx_on", rx_on, men);
        if (mq.size() > 0)
            chk({rd_brk, rd_fe, rd_pe, rd_data} == mq[0], "R1", "head",
                {rd_brk, rd_fe, rd_pe, rd_data}, mq[0]);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic push_ch(input logic [7:0] d, input bit b, input bit f, input bit p);
        push_valid = 1; push_data = d; push_brk = b; push_fe = f; push_pe = p;
        tick();
    endtask

    task automatic cmd(input logic [4:0] c);
        cmd_valid = 1; cmd_code = c;
        tick();
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle_inputs();
        rst = 1;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        chk(stat == 8'h00 && level == 0 && rx_on == 0, "R11", "reset state", stat, 0);

        // R11: pushes ignored while off
        push_ch(8'hA5, 0, 0, 0);
        chk(level == 0, "R11", "push while off", level, 0);
        en_wr = 1; en_val = 1; tick();

        // R1 / R3: fill to sixteen
        for (int i = 0; i < 16; i++) push_ch(8'(i + 1), 0, 0, 0);
        chk(stat[1] == 1'b1, "R3", "full after 16", stat[1], 1);
        // R4: seventeenth waits in the slot
        push_ch(8'h77, 0, 0, 0);
        chk(level == 16, "R4", "slot level", level, 16);
        // R5: eighteenth overruns
        cur_tag = "R5";
        push_ch(8'h88, 1, 1, 1);
        chk(stat[4] == 1'b1 && stat[7:5] == 3'b000, "R5", "overrun bits", stat[7:4], 4'b0001);
        // R4: first read keeps full
        pop = 1; tick();
        chk(stat[1] == 1'b1 && level == 16, "R4", "full after one read", level, 16);
        pop = 1; tick();
        chk(level == 15, "R4", "second read", level, 15);
        // R6: pop and push together
        cur_tag = "R6";
        pop = 1; push_valid = 1; push_data = 8'h99; tick();
        chk(level == 15, "R6", "paired level", level, 15);
        cmd(5'b00100);
        chk(stat[7:4] == 0, "R9", "clear", stat[7:4], 0);

        // R7: framing flag appears only when the entry reaches the head
        cur_tag = "R7";
        push_ch(8'h5F, 0, 1, 0);
        chk(stat[6] == 1'b0, "R7", "fe early", stat[6], 0);
        for (int i = 0; i < 15; i++) begin pop = 1; tick(); end
        tick();
        chk(stat[6] == 1'b1, "R7", "fe at head", stat[6], 1);
        // R9: cleared flag not gathered again from the same head
        cur_tag = "R9";
        cmd(5'b00100); tick(); tick();
        chk(stat[6] == 1'b0, "R9", "no re-gather", stat[6], 0);
        while (mq.size() > 0) begin pop = 1; tick(); end
        // R13: read of empty and unused commands
        pop = 1; tick();
        chk(level == 0, "R13", "empty read", level, 0);
        cmd(5'b00111); cmd(5'b11111);
        chk(stat == 8'h00 && rx_on, "R13", "unused commands", stat, 0);

        // R12: break takes one position and blocks
        cur_tag = "R12";
        push_ch(8'h00, 1, 1, 0);
        push_ch(8'h11, 0, 0, 0);
        push_ch(8'h22, 0, 0, 0);
        chk(level == 1, "R12", "blocked after break", level, 1);
        line_mark = 1; tick();
        push_ch(8'h33, 0, 0, 0);
        chk(level == 2, "R12", "released", level, 2);

        // R8: push-time accumulation
        cur_tag = "R8";
        cmd(5'b00100);
        cmd(5'b01101);
        push_ch(8'h44, 0, 0, 1);
        chk(stat[5] == 1'b1, "R8", "pe at push", stat[5], 1);
        cmd(5'b00100);
        pop = 1; tick(); tick(); tick();
        chk(stat[7:4] == 0, "R8", "no head gather", stat[7:4], 0);

        // R10: receiver reset
        cur_tag = "R10";
        cmd(5'b00010);
        chk(level == 0 && stat == 0 && rx_on == 0, "R10", "rx reset", {level, stat}, 0);

        // random phases
        cur_tag = "R7";
        for (int ph = 0; ph < 8; ph++) begin
            int pp = (ph % 2 == 0) ? 85 : 30;
            int rp = (ph % 2 == 0) ? 25 : 80;
            for (int k = 0; k < 400; k++) begin
                int r;
                push_valid = ($urandom % 100) < pp;
                push_data  = 8'($urandom);
                push_fe    = ($urandom % 8) == 0;
                push_pe    = ($urandom % 8) == 0;
                push_brk   = ($urandom % 40) == 0;
                pop        = ($urandom % 100) < rp;
                line_mark  = ($urandom % 4) == 0;
                if (!men) begin en_wr = ($urandom % 5) == 0; en_val = 1; end
                r = $urandom % 400;
                if (r < 4)       begin cmd_valid = 1; cmd_code = 5'b00100; end
                else if (r < 6)  begin cmd_valid = 1; cmd_code = 5'b01101; end
                else if (r < 7)  begin cmd_valid = 1; cmd_code = 5'b00010; end
                else if (r < 10) begin cmd_valid = 1; cmd_code = 5'($urandom); end
                tick();
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule